// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Sequencer

This block pairs two eight-line priority resolvers, a primary and a secondary. The secondary's "has a winner" output feeds the primary's line 2 as a one-sample pulse. Because the pulse is treated as an edge, the primary holds a request for the whole secondary group until that request is acknowledged. The primary's winner drives a registered interrupt line toward the processor.

When the processor raises the acknowledge strobe for one cycle, the block takes the current primary winner and updates that resolver's request and in-service state. If the winner is line 2, the block also acknowledges the secondary. One cycle later it returns an 8-bit vector with a one-cycle valid pulse. The upper five bits of the vector come from the per-resolver base input and the lower three bits from the line number. When no request remains at acknowledge time, the block returns line 7 of the resolver involved.

Trigger mode (level or edge per line), auto end-of-interrupt and rotation on auto end-of-interrupt are static inputs. Programming them is left to the surrounding logic.

Top module: `cascade_ack_seq`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are 0, no request or in-service bit is set, and the rotation offset of both resolvers is 0.
- R2: Bus bits 0-7 of `irq_in` are primary lines 0-7 and bits 8-15 are secondary lines 0-7. A line with its `level_sel` bit at 0 is edge mode, and a 0-to-1 change on it latches a request. A pending primary winner raises `int_out` within three clock edges of the line rising.
- R3: With rotation offset 0, line 0 has the highest priority and line 7 the lowest, in each resolver. When two lines are pending, the lower-numbered one is acknowledged first.
- R4: Bit 2 of `irq_in` has no effect. Primary line 2 is set only when the secondary has a winner, and it is latched as an edge.
- R5: One cycle after `ack` is sampled high, `vec_valid` is 1 for exactly one cycle. For a primary winner other than line 2, `vec_out` is {master_base[7:3], line[2:0]}. The low three bits of the base are ignored.
- R6: When the primary winner is line 2 and the secondary has a winner, both resolvers are acknowledged and `vec_out` is {slave_base[7:3], secondary line}.
- R7: A spurious acknowledge returns line 7. If the primary has no winner, `vec_out` is {master_base[7:3], 3'd7}. If the primary winner is line 2 but the secondary has none, `vec_out` is {slave_base[7:3], 3'd7}.
- R8: Acknowledge clears the request of an edge-mode winner. A level-mode winner (`level_sel` bit 1) keeps its request while its input stays high, so `int_out` asserts again.
- R9: With `auto_eoi` at 0, acknowledge sets the winner's in-service bit. That bit blocks lines of equal or lower priority, and a higher-priority line still interrupts.
- R10: With `auto_eoi` at 1, no in-service bit is retained. If `rotate_aeoi` is also 1, the acknowledged resolver's rotation offset becomes (line+1) mod 8, so the line just served becomes the lowest priority.
- R11: `int_out` is 0 in the cycle after an acknowledge and is re-evaluated from the updated state from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request lines, primary in bits 7:0, secondary in bits 15:8 |
| level_sel | input | 16 | Per-line trigger mode, 1 = level, 0 = edge (bit 2 ignored) |
| auto_eoi | input | 1 | Clear in-service as part of the acknowledge |
| rotate_aeoi | input | 1 | Rotate priority on auto end-of-interrupt |
| ack | input | 1 | One-cycle acknowledge strobe |
| master_base | input | 8 | Primary vector base, bits 7:3 used |
| slave_base | input | 8 | Secondary vector base, bits 7:3 used |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle pulse marking `vec_out` valid |
| vec_out | output | 8 | Acknowledged vector |

## Verification
The assertions assume that the mode inputs stay steady around an acknowledge. They also assume that no new edge arrives on a line in the same cycle that line is acknowledged, since the acknowledge clear takes precedence and would hide the edge. The stimulus changes `level_sel` and the mode bits only while the related lines are low and no acknowledge is pending. It lowers each edge line for several cycles before raising it again, and it raises the strobe only at a falling clock edge, one cycle at a time.

// File: rtl/casc_pkg.sv
// Package: shared constants and the vector-source encoding for the
// two-level acknowledge sequencer. Assumes power-of-two line counts.
package casc_pkg;
    localparam int CTRL_LINES = 8;
    localparam int VECTOR_W   = 8;
    localparam int CASC_LINE  = 2;

    typedef enum logic [1:0] {
        SRC_PRIMARY   = 2'd0,
        SRC_SECONDARY = 2'd1,
        SRC_SPUR_PRI  = 2'd2,
        SRC_SPUR_SEC  = 2'd3
    } vec_src_e;
endpackage

// File: rtl/prio_pick.sv
// Module: rotating priority picker. Finds the set bit of vec closest
// to position base (walking upward with wrap), and returns its rank
// (distance from base) and its index. rank equals LINES when vec is 0.
// Assumes LINES is a power of two so index arithmetic wraps naturally.
module prio_pick #(
    parameter int LINES = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [IW-1:0]    base,
    output logic             found,
    output logic [IW:0]      rank,
    output logic [IW-1:0]    idx
);
    // Scan from lowest priority to highest so the last hit wins.
    always_comb begin
        logic [IW-1:0] pos;
        found = 1'b0;
        rank  = (IW+1)'(LINES);
        idx   = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            pos = base + IW'(k);
            if (vec[pos]) begin
                found = 1'b1;
                rank  = (IW+1)'(k);
                idx   = pos;
            end
        end
    end
endmodule

// File: rtl/prio_core.sv
// Module: one eight-line priority resolver. It holds the request,
// in-service and last-sample registers and a rotation offset, and it
// reports a winner when the best pending request outranks everything
// in service. Assumes ack is one cycle wide and that pulse_set lines
// are edge style (set-only inputs driven by a neighbour).
module prio_core #(
    parameter int LINES = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] level_sel,
    input  logic [LINES-1:0] pulse_set,
    input  logic             ack,
    input  logic             auto_eoi,
    input  logic             rotate_aeoi,
    output logic             win_valid,
    output logic [IW-1:0]    win_idx,
    output logic [LINES-1:0] irr_o,
    output logic [LINES-1:0] isr_o
);
    logic [LINES-1:0] irr_q, isr_q, last_q, irr_n;
    logic [IW-1:0]    rot_q;
    logic             req_found, srv_found;
    logic [IW:0]      req_rank, srv_rank;
    logic [IW-1:0]    srv_idx;
    logic             take;

    prio_pick #(.LINES(LINES)) pick_req_i (
        .vec(irr_q), .base(rot_q),
        .found(req_found), .rank(req_rank), .idx(win_idx)
    );
    prio_pick #(.LINES(LINES)) pick_srv_i (
        .vec(isr_q), .base(rot_q),
        .found(srv_found), .rank(srv_rank), .idx(srv_idx)
    );

    assign win_valid = req_found && (req_rank < srv_rank);
    assign take      = ack && win_valid;
    assign irr_o     = irr_q;
    assign isr_o     = isr_q;

    // Next request state: sample lines per mode, add pulses, clear on ack.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            if (level_sel[i])
                irr_n[i] = req[i];
            else
                irr_n[i] = irr_q[i] | (req[i] & ~last_q[i]);
            irr_n[i] = irr_n[i] | pulse_set[i];
            if (take && (win_idx == IW'(i)) && !level_sel[i])
                irr_n[i] = 1'b0;
        end
    end

    // State registers: requests, edge history, in-service and rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            isr_q  <= '0;
            last_q <= '0;
            rot_q  <= '0;
        end else begin
            irr_q  <= irr_n;
            last_q <= req;
            if (take && !auto_eoi)
                isr_q[win_idx] <= 1'b1;
            if (take && auto_eoi && rotate_aeoi)
                rot_q <= win_idx + IW'(1);
        end
    end
endmodule

// File: rtl/cascade_ack_seq.sv
// Module: two-level acknowledge sequencer. A secondary resolver's
// winner pulses primary line 2. On ack the primary winner (and, via
// line 2, the secondary winner) is acknowledged and an 8-bit vector
// is returned one cycle later with a one-cycle valid pulse.
// Assumes ack is a single-cycle strobe and mode inputs are static.
module cascade_ack_seq
    import casc_pkg::*;
#(
    parameter int LINES     = CTRL_LINES,
    parameter int VEC_W     = VECTOR_W,
    parameter int CASCADE   = CASC_LINE,
    localparam int IW       = $clog2(LINES),
    localparam int BUS_W    = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] irq_in,
    input  logic [BUS_W-1:0] level_sel,
    input  logic             auto_eoi,
    input  logic             rotate_aeoi,
    input  logic             ack,
    input  logic [VEC_W-1:0] master_base,
    input  logic [VEC_W-1:0] slave_base,
    output logic             int_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);
    localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE;

    logic             m_wv, s_wv, s_ack;
    logic [IW-1:0]    m_wi, s_wi;
    logic [LINES-1:0] m_irr, m_isr, s_irr, s_isr;
    logic [LINES-1:0] m_req, m_level, m_pulse;
    logic [IW-1:0]    sel_idx;
    logic [VEC_W-1:0] sel_base;
    vec_src_e         src;
    logic             int_q, vv_q;
    logic [VEC_W-1:0] vec_q;

    // Primary inputs: cascade line driven only by the secondary pulse.
    assign m_req   = irq_in[LINES-1:0] & ~CASC_BIT;
    assign m_level = level_sel[LINES-1:0] & ~CASC_BIT;
    assign m_pulse = s_wv ? CASC_BIT : '0;
    assign s_ack   = ack && m_wv && (m_wi == IW'(CASCADE));

    prio_core #(.LINES(LINES)) pri_i (
        .clk(clk), .rst_n(rst_n), .req(m_req), .level_sel(m_level),
        .pulse_set(m_pulse), .ack(ack), .auto_eoi(auto_eoi),
        .rotate_aeoi(rotate_aeoi), .win_valid(m_wv), .win_idx(m_wi),
        .irr_o(m_irr), .isr_o(m_isr)
    );
    prio_core #(.LINES(LINES)) sec_i (
        .clk(clk), .rst_n(rst_n), .req(irq_in[BUS_W-1:LINES]),
        .level_sel(level_sel[BUS_W-1:LINES]), .pulse_set('0),
        .ack(s_ack), .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi),
        .win_valid(s_wv), .win_idx(s_wi), .irr_o(s_irr), .isr_o(s_isr)
    );

    // Classify the acknowledge outcome.
    always_comb begin
        if (!m_wv)
            src = SRC_SPUR_PRI;
        else if (m_wi != IW'(CASCADE))
            src = SRC_PRIMARY;
        else if (s_wv)
            src = SRC_SECONDARY;
        else
            src = SRC_SPUR_SEC;
    end

    // Pick the base and line number for the returned vector.
    always_comb begin
        unique case (src)
            SRC_PRIMARY:   begin sel_base = master_base; sel_idx = m_wi; end
            SRC_SECONDARY: begin sel_base = slave_base;  sel_idx = s_wi; end
            SRC_SPUR_SEC:  begin sel_base = slave_base;  sel_idx = IW'(LINES - 1); end
            default:       begin sel_base = master_base; sel_idx = IW'(LINES - 1); end
        endcase
    end

    // Output registers: interrupt line, vector and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
            vv_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            int_q <= ack ? 1'b0 : m_wv;
            vv_q  <= ack;
            if (ack)
                vec_q <= {sel_base[VEC_W-1:IW], sel_idx};
        end
    end

    assign int_out   = int_q;
    assign vec_valid = vv_q;
    assign vec_out   = vec_q;
endmodule

// File: rtl/cascade_ack_seq_chk.sv
// Module: property checker for the two-level acknowledge sequencer,
// bound to the top. Assumes single-cycle ack and static mode inputs.
module cascade_ack_seq_chk #(
    parameter int LINES = 8,
    parameter int VEC_W = 8,
    parameter int CASCADE = 2,
    localparam int IW = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             auto_eoi,
    input logic             int_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic [VEC_W-1:0] master_base,
    input logic [VEC_W-1:0] slave_base,
    input logic             m_wv,
    input logic [IW-1:0]    m_wi,
    input logic [LINES-1:0] m_level,
    input logic [LINES-1:0] m_irr,
    input logic [LINES-1:0] m_isr,
    input logic [LINES-1:0] s_isr
);
    // R5: an acknowledge produces a valid vector on the next cycle.
    assert_vec_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    // R5: the valid pulse never appears without a preceding acknowledge.
    assert_vec_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack));

    // R6, R7: upper vector bits come from the base of the resolver involved.
    assert_vec_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:IW] ==
            ($past(m_wv && (m_wi == IW'(CASCADE))) ?
                $past(slave_base[VEC_W-1:IW]) : $past(master_base[VEC_W-1:IW]))));

    // R8: an acknowledged edge-mode primary request is gone afterwards.
    assert_edge_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && m_wv && !m_level[m_wi]) |=> !m_irr[$past(m_wi)]);

    // R10: auto end-of-interrupt leaves the in-service state untouched.
    assert_aeoi_pri_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi) |=> (m_isr == $past(m_isr)));
    assert_aeoi_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi) |=> (s_isr == $past(s_isr)));

    // R11: the interrupt line is low in the cycle after an acknowledge.
    assert_int_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !int_out);
endmodule

bind cascade_ack_seq cascade_ack_seq_chk #(
    .LINES(LINES), .VEC_W(VEC_W), .CASCADE(CASCADE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ack(ack), .auto_eoi(auto_eoi),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
    .master_base(master_base), .slave_base(slave_base),
    .m_wv(m_wv), .m_wi(m_wi), .m_level(m_level), .m_irr(m_irr),
    .m_isr(m_isr), .s_isr(s_isr)
);

// File: tb/cascade_ack_seq_tb.sv
// Bench: table-driven single-line acknowledges, then directed tests.
module cascade_ack_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [15:0] level_sel = '0;
    logic        auto_eoi = 1'b1;
    logic        rotate_aeoi = 1'b0;
    logic        ack = 1'b0;
    logic [7:0]  master_base = 8'h23;
    logic [7:0]  slave_base = 8'h6D;
    logic        int_out, vec_valid;
    logic [7:0]  vec_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cascade_ack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel),
        .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .ack(ack),
        .master_base(master_base), .slave_base(slave_base),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // Table: {bus line, expected vector}; bases 8'h23 and 8'h6D.
    localparam logic [11:0] TBL [8] = '{
        {4'd0,  8'h20}, {4'd3,  8'h23}, {4'd7,  8'h27}, {4'd9,  8'h69},
        {4'd15, 8'h6F}, {4'd12, 8'h6C}, {4'd6,  8'h26}, {4'd1,  8'h21}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_int(output logic seen);
        seen = 1'b0;
        for (int k = 0; k < 12 && !seen; k++) begin
            @(negedge clk);
            seen = int_out;
        end
    endtask

    // Pulse ack for one cycle; sample results after the capturing edge.
    task automatic do_ack(output logic vv, output logic [7:0] v, output logic il);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        vv = vec_valid;
        v  = vec_out;
        il = int_out;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic seen, vv, il;
        logic [7:0] v;
        step(3);
        // R1: reset state
        chk("R1 int", {7'd0, int_out}, 8'd0);
        chk("R1 vv", {7'd0, vec_valid}, 8'd0);
        rst_n = 1'b1;
        step(2);
        chk("R1 int after release", {7'd0, int_out}, 8'd0);

        // Table walk: one edge line at a time (R2, R5, R6, R8, R11)
        for (int i = 0; i < 8; i++) begin
            int line;
            line = int'(TBL[i][11:8]);
            irq_in[line] = 1'b1;
            wait_int(seen);
            chk("R2 int raised", {7'd0, seen}, 8'd1);
            do_ack(vv, v, il);
            chk("R5 vec_valid", {7'd0, vv}, 8'd1);
            chk(line >= 8 ? "R6 vector" : "R5 vector", v, TBL[i][7:0]);
            chk("R11 int low after ack", {7'd0, il}, 8'd0);
            irq_in[line] = 1'b0;
            step(3);
            chk("R8 edge cleared", {7'd0, int_out}, 8'd0);
        end

        // R5: valid lasts one cycle
        step(1);
        chk("R5 single pulse", {7'd0, vec_valid}, 8'd0);

        // R4: external bit 2 ignored; then R7 spurious primary
        irq_in[2] = 1'b1;
        step(5);
        chk("R4 bit2 ignored", {7'd0, int_out}, 8'd0);
        do_ack(vv, v, il);
        chk("R7 spurious primary", v, 8'h27);
        irq_in[2] = 1'b0;
        step(2);

        // R8: level line stays pending after ack
        level_sel[5] = 1'b1;
        irq_in[5] = 1'b1;
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R8 level vector", v, 8'h25);
        step(2);
        chk("R8 level re-asserts", {7'd0, int_out}, 8'd1);
        irq_in[5] = 1'b0;
        step(3);
        chk("R8 level released", {7'd0, int_out}, 8'd0);
        level_sel[5] = 1'b0;

        // R3: two primary lines, lower number first
        irq_in[1] = 1'b1;
        irq_in[6] = 1'b1;
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R3 first winner", v, 8'h21);
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R3 second winner", v, 8'h26);
        irq_in[1] = 1'b0;
        irq_in[6] = 1'b0;
        step(3);

        // R7: secondary spurious via level line dropped before ack
        level_sel[11] = 1'b1;
        irq_in[11] = 1'b1;
        wait_int(seen);
        irq_in[11] = 1'b0;
        step(3);
        do_ack(vv, v, il);
        chk("R7 spurious secondary", v, 8'h6F);
        step(2);
        chk("R7 no retrigger", {7'd0, int_out}, 8'd0);
        level_sel[11] = 1'b0;

        // R6/R3: two secondary lines served in priority order
        irq_in[9] = 1'b1;
        irq_in[12] = 1'b1;
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R6 secondary first", v, 8'h69);
        wait_int(seen);
        chk("R6 cascade re-raises", {7'd0, seen}, 8'd1);
        do_ack(vv, v, il);
        chk("R6 secondary second", v, 8'h6C);
        irq_in[9] = 1'b0;
        irq_in[12] = 1'b0;
        step(3);

        // R10: rotation on auto end-of-interrupt
        rotate_aeoi = 1'b1;
        irq_in[1] = 1'b1;
        irq_in[3] = 1'b1;
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R10 before rotation", v, 8'h21);
        irq_in[1] = 1'b0;
        irq_in[3] = 1'b0;
        step(2);
        irq_in[1] = 1'b1;
        step(3);
        do_ack(vv, v, il);
        chk("R10 rotated winner", v, 8'h23);
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R10 rotated last", v, 8'h21);
        irq_in[1] = 1'b0;
        rotate_aeoi = 1'b0;

        // R1: reset clears state
        do_reset();
        chk("R1 int after reset", {7'd0, int_out}, 8'd0);
        chk("R1 vv after reset", {7'd0, vec_valid}, 8'd0);

        // R9: in-service blocking without auto end-of-interrupt
        auto_eoi = 1'b0;
        step(2);
        irq_in[4] = 1'b1;
        wait_int(seen);
        do_ack(vv, v, il);
        chk("R9 first", v, 8'h24);
        irq_in[4] = 1'b0;
        irq_in[6] = 1'b1;
        step(5);
        chk("R9 lower blocked", {7'd0, int_out}, 8'd0);
        irq_in[0] = 1'b1;
        wait_int(seen);
        chk("R9 higher interrupts", {7'd0, seen}, 8'd1);
        do_ack(vv, v, il);
        chk("R9 higher vector", v, 8'h20);
        step(3);
        chk("R9 still blocked", {7'd0, int_out}, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule